// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator

This block takes two 32-bit single-precision floating-point words and orders them. It returns one of four registered outcomes: the first operand is below the second, the two are equal, the first is above the second, or the pair is unordered because at least one operand is not a number. Each word is split into a sign, an 8-bit biased exponent and a 23-bit fraction. The biased exponent makes the 31 magnitude bits of a word sort correctly as an unsigned integer, so one integer comparator does the magnitude work. The sign then picks the final answer, and a negative pair reverses the magnitude result.

The operands are sampled together with an input strobe on a rising clock edge. The flags and an output strobe appear one cycle later. Reset is synchronous and active-high.

Top module: `fpcmp_top`

## Requirements
- R1: Fields are sign = bit 31, exponent = bits 30..23, fraction = bits 22..0. When both operands are non-negative and not NaN, the outcome follows the unsigned value of bits 30..0, for example 0x3F000000 (0.5) < 0x40000000 (2.0).
- R2: A negative operand (sign 1) always orders below a positive operand (sign 0), unless either operand is NaN or both are zero.
- R3: When both operands are negative, the order of the 31-bit magnitudes is reversed, for example 0xC0000000 (-2.0) < 0xBF000000 (-0.5).
- R4: Two operands with the same exponent order by their fraction. Operands with exponent 0 are ordered by their fraction and have no implicit leading 1, so 0x00000001 < 0x00800000.
- R5: +0 (0x00000000) and -0 (0x80000000) compare equal, in either order and in any pairing of the two.
- R6: An operand with exponent 255 and a nonzero fraction is NaN. Any NaN sets the unordered flag and clears the less, equal and greater flags. Infinities (exponent 255, fraction 0) order normally.
- R7: Exactly one of less, equal, greater and unordered is high whenever out_valid is high.
- R8: out_valid equals the in_valid sampled one clock edge earlier. The flags on that cycle belong to the operands sampled on that same edge.
- R9: A synchronous reset clears out_valid and all four flags on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| lt | output | 1 | op_a orders below op_b |
| eq | output | 1 | op_a equals op_b |
| gt | output | 1 | op_a orders above op_b |
| unord | output | 1 | At least one operand is NaN |

## Verification
Every bad decode shows on the flags in the cycle after the operands are sampled, because the pipeline has one register stage. A sign swap shows as lt and gt trading places. A missed negative-pair reversal shows in the same way, but only when both signs are set. A zero-handling slip shows as eq dropping for a mixed-sign pair of zeros, and a NaN decode error shows as unord staying low while an ordering flag rises. A stuck strobe register shows at once as out_valid not following in_valid by one cycle.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MAG_W  = EXP_W + FRAC_W;
    localparam logic [EXP_W-1:0] EXP_ALL_ONES = '1;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             is_nan;
        logic             is_zero;
    } fp_class_t;

    typedef enum logic [1:0] {
        ORD_LT = 2'd0,
        ORD_EQ = 2'd1,
        ORD_GT = 2'd2,
        ORD_UN = 2'd3
    } order_e;

    function automatic fp_class_t classify(input fp_word_t w);
        fp_class_t c;
        c.sign    = w.sign;
        c.mag     = {w.exp, w.frac};
        c.is_nan  = (w.exp == EXP_ALL_ONES) && (w.frac != '0);
        c.is_zero = (w.exp == '0) && (w.frac == '0);
        return c;
    endfunction
endpackage

// File: rtl/fpcmp_unpack.sv
module fpcmp_unpack
    import fpcmp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fp_class_t         cls
);
    always_comb cls = classify(fp_word_t'(word));
endmodule

// File: rtl/fpcmp_decide.sv
module fpcmp_decide
    import fpcmp_pkg::*;
(
    input  fp_class_t a,
    input  fp_class_t b,
    output order_e    ord
);
    logic mag_lt, mag_eq;

    always_comb begin
        mag_lt = a.mag < b.mag;
        mag_eq = a.mag == b.mag;
        if (a.is_nan || b.is_nan)
            ord = ORD_UN;
        else if (a.is_zero && b.is_zero)
            ord = ORD_EQ;
        else if (a.sign != b.sign)
            ord = a.sign ? ORD_LT : ORD_GT;
        else if (mag_eq)
            ord = ORD_EQ;
        else if (a.sign)
            ord = mag_lt ? ORD_GT : ORD_LT;
        else
            ord = mag_lt ? ORD_LT : ORD_GT;
    end

    always_comb begin
        assert_zero_pair_R5: assert (!(a.is_zero && b.is_zero && !a.is_nan && !b.is_nan) || ord == ORD_EQ)
            else $error("R5 signed zeros not equal");
    end
endmodule

// File: rtl/fpcmp_top.sv
module fpcmp_top
    import fpcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              out_valid,
    output logic              lt,
    output logic              eq,
    output logic              gt,
    output logic              unord
);
    fp_class_t ca, cb;
    order_e    ord;

    fpcmp_unpack u_ua (.word(op_a), .cls(ca));
    fpcmp_unpack u_ub (.word(op_b), .cls(cb));
    fpcmp_decide u_dec (.a(ca), .b(cb), .ord(ord));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            lt <= 1'b0; eq <= 1'b0; gt <= 1'b0; unord <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                lt    <= (ord == ORD_LT);
                eq    <= (ord == ORD_EQ);
                gt    <= (ord == ORD_GT);
                unord <= (ord == ORD_UN);
            end
        end
    end

    assert_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $countones({lt, eq, gt, unord}) == 1);
    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid));
    assert_reset_R9: assert property (@(posedge clk)
        $past(rst) |-> !out_valid && !lt && !eq && !gt && !unord);
    assert_nan_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (ca.is_nan || cb.is_nan)) |=> unord && !lt && !eq && !gt);
    assert_sign_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_a[31] && !op_b[31] && !ca.is_nan && !cb.is_nan && !(ca.is_zero && cb.is_zero)) |=> lt);
endmodule

// File: tb/sim_fpcmp_top.sv
`timescale 1ns/1ps
module sim_fpcmp_top;
    logic clk = 0, rst = 1, in_valid = 0;
    logic [31:0] op_a = '0, op_b = '0;
    logic out_valid, lt, eq, gt, unord;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    fpcmp_top u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
                  .out_valid(out_valid), .lt(lt), .eq(eq), .gt(gt), .unord(unord));

    localparam int NV = 20;
    localparam logic [63:0] VEC [NV] = '{
        {32'h3F000000, 32'h40000000}, {32'h40000000, 32'h3F000000},
        {32'hBF800000, 32'h3F800000}, {32'h3F800000, 32'hBF800000},
        {32'hC0000000, 32'hBF000000}, {32'hBF000000, 32'hC0000000},
        {32'h3FC00000, 32'h3FA00000}, {32'h3FA00000, 32'h3FC00000},
        {32'h00000001, 32'h00800000}, {32'h00000000, 32'h80000000},
        {32'h80000000, 32'h00000000}, {32'h80000000, 32'h80000000},
        {32'h7F800000, 32'h7F7FFFFF}, {32'hFF800000, 32'h7F800000},
        {32'h7FC00000, 32'h3F800000}, {32'h3F800000, 32'h7F800001},
        {32'hFFC00000, 32'hFFC00000}, {32'h42F60000, 32'h42F60000},
        {32'hC1700000, 32'hC1700000}, {32'h80000001, 32'h00000000}
    };

    function automatic real to_real(input logic [31:0] w);
        real m; int e;
        e = int'(w[30:23]);
        if (e == 0) begin m = real'(w[22:0]) / 8388608.0; e = -126; end
        else begin m = 1.0 + real'(w[22:0]) / 8388608.0; e = e - 127; end
        for (int i = 0; i < e; i++) m = m * 2.0;
        for (int i = 0; i > e; i--) m = m / 2.0;
        return w[31] ? -m : m;
    endfunction

    function automatic logic [3:0] expect_flags(input logic [31:0] a, input logic [31:0] b);
        real ra, rb;
        if ((a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0))
            return 4'b0001;
        ra = to_real(a); rb = to_real(b);
        if (ra < rb) return 4'b1000;
        if (ra > rb) return 4'b0010;
        return 4'b0100;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp_v);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic v);
        @(negedge clk); op_a = a; op_b = b; in_valid = v;
    endtask

    initial begin
        logic [3:0] e;
        repeat (2) @(negedge clk);
        rst = 0;
        // R9 reset state
        check("R9", {out_valid, lt|eq|gt|unord, 2'b00}, 4'b0000);
        // R1 R2 R3 R4 R5 R6 R7 R8: vector table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][63:32], VEC[i][31:0], 1'b1);
            e = expect_flags(VEC[i][63:32], VEC[i][31:0]);
            @(negedge clk);
            check("R1-vector R8 valid", {3'b000, out_valid}, 4'b0001);
            check(i < 2 ? "R1" : i < 4 ? "R2" : i < 6 ? "R3" : i < 9 ? "R4" :
                  i < 12 ? "R5" : i < 17 ? "R6" : "R7", {lt, eq, gt, unord}, e);
            in_valid = 0;
        end
        // R8: idle strobe drops after one cycle
        drive(32'h3F800000, 32'h40000000, 1'b0);
        @(negedge clk);
        check("R8", {3'b000, out_valid}, 4'b0000);
        // R8 back-to-back
        drive(32'h40000000, 32'h3F800000, 1'b1);
        drive(32'h3F800000, 32'h40000000, 1'b1);
        check("R8", {lt, eq, gt, unord}, 4'b0010);
        @(negedge clk); in_valid = 0;
        check("R8", {lt, eq, gt, unord}, 4'b1000);
        // R9 reset mid-stream
        drive(32'h3F800000, 32'h3F800000, 1'b1);
        rst = 1;
        @(negedge clk);
        check("R9", {out_valid, lt, eq, gt}, 4'b0000);
        check("R9", {3'b000, unord}, 4'b0000);
        rst = 0; in_valid = 0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule